// File: doc/BRIEF.md
# Virtual-Alias Duplicate Invalidator

This block sits beside the tag array of a two-way cache that is indexed with virtual address bits and tagged with physical page numbers. A page is smaller than one cache way, so the upper bits of the set index come from the virtual page number. One physical line can therefore sit in several sets, one for each value of those alias bits. When a miss has been translated, the block walks every set the line could occupy and reads the tags of both ways in each one. Any valid entry whose tag equals the physical page number of the missing line is invalidated. The block then pulses done, and the refill can write the line knowing that no other copy of it is left in the cache.

A miss supplies the set-index bits that lie inside the page offset and the physical tag. The block forms each candidate set by putting the alias value on top of those bits. It issues one tag-array read per candidate and expects the data back one cycle later, as block RAM returns it. It drives an invalidate strobe with a per-way mask. When the walk ends it reports how many entries it cleared.

Top module: `alias_inval_checker`

## Requirements
- R1: While reset is high and in the cycle after it, idle is 1 and done, rd_en and inv_en are 0. inv_count is 0 after reset.
- R2: A miss is taken only when idle is 1. miss_valid raised during a walk is ignored: it causes no extra reads, no invalidations and no extra done pulse. idle returns to 1 in the cycle after done.
- R3: For each miss, exactly four reads are issued. Their rd_set is {alias, miss_pidx}, with the alias in the top two bits. The alias takes the values 0, 1, 2, 3 in that order.
- R4: The cycle after a read, inv_en is raised when an entry of that set is valid and its tag equals miss_ptag. inv_set then names the set that was read, and bit w of inv_way clears way w.
- R5: When both ways of a candidate set match, both bits of inv_way are set in the same cycle.
- R6: Entries that are invalid, or whose tag differs, are left as they are, and so are entries in sets outside the four candidates.
- R7: done is high for exactly one cycle, eight cycles after the clock edge that takes the miss.
- R8: While done is high, inv_count equals the number of entries invalidated for that miss (0 to 8). It holds that value until the next miss is taken.
- R9: After done, no valid entry in any candidate set holds miss_ptag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Miss request strobe |
| miss_pidx | input | 6 | Set-index bits inside the page offset |
| miss_ptag | input | 20 | Physical page number of the missing line |
| idle | output | 1 | Ready to accept a miss |
| rd_en | output | 1 | Tag-array read strobe |
| rd_set | output | 8 | Set to read |
| rd_valid | input | 2 | Valid bits returned, one per way, one cycle after rd_en |
| rd_tags | input | 40 | Returned tags, way 0 in the low 20 bits |
| inv_en | output | 1 | Invalidate strobe |
| inv_set | output | 8 | Set to invalidate |
| inv_way | output | 2 | Ways to invalidate |
| done | output | 1 | Walk complete, one-cycle pulse |
| inv_count | output | 4 | Entries invalidated by the last walk |

## Verification
The assertions rely on the tag array answering every read in the very next cycle. They also rely on the array applying an invalidate at the edge where inv_en is sampled, so that a later read sees the result. The bench models the array that way, with a one-cycle registered read port. Each test sets up the tag contents before it raises miss_valid, so no other agent writes the array during a walk. The only miss_valid that overlaps a walk is the one deliberately raised to check R2.

// File: rtl/aic_pkg.sv
package aic_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROBE = 2'd1,
    ST_INVAL = 2'd2,
    ST_DONE  = 2'd3
  } aic_state_e;
endpackage

// File: rtl/aic_alias_seq.sv
module aic_alias_seq #(
  parameter int ALIAS_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               step,
  output logic [ALIAS_W-1:0] alias_q,
  output logic               last
);
  localparam logic [ALIAS_W-1:0] TOP = {ALIAS_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clear) alias_q <= '0;
    else if (step)    alias_q <= alias_q + 1'b1;
  end

  assign last = (alias_q == TOP);

  // R3
  alias_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !clear) |=> (alias_q == $past(alias_q) + 1'b1));

  // R3
  alias_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> (alias_q == '0));
endmodule

// File: rtl/aic_tag_match.sv
module aic_tag_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 20,
  parameter int CNT_W = 4
) (
  input  logic [WAYS-1:0]       way_valid,
  input  logic [WAYS*TAG_W-1:0] way_tags,
  input  logic [TAG_W-1:0]      ref_tag,
  output logic [WAYS-1:0]       hit,
  output logic [CNT_W-1:0]      hit_cnt
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit[w] = way_valid[w] && (way_tags[w*TAG_W +: TAG_W] == ref_tag);
  end

  always_comb begin
    hit_cnt = '0;
    for (int w = 0; w < WAYS; w++) hit_cnt = hit_cnt + CNT_W'(hit[w]);
  end
endmodule

// File: rtl/alias_inval_checker.sv
module alias_inval_checker
  import aic_pkg::*;
#(
  parameter int PADDR_W = 32,
  parameter int PAGE_W  = 12,
  parameter int LINE_W  = 6,
  parameter int SET_W   = 8,
  parameter int WAYS    = 2,
  localparam int TAG_W  = PADDR_W - PAGE_W,
  localparam int LOW_W  = PAGE_W - LINE_W,
  localparam int NCAND  = WAYS << (SET_W - LOW_W),
  localparam int CNT_W  = $clog2(NCAND + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  miss_valid,
  input  logic [LOW_W-1:0]      miss_pidx,
  input  logic [TAG_W-1:0]      miss_ptag,
  output logic                  idle,
  output logic                  rd_en,
  output logic [SET_W-1:0]      rd_set,
  input  logic [WAYS-1:0]       rd_valid,
  input  logic [WAYS*TAG_W-1:0] rd_tags,
  output logic                  inv_en,
  output logic [SET_W-1:0]      inv_set,
  output logic [WAYS-1:0]       inv_way,
  output logic                  done,
  output logic [CNT_W-1:0]      inv_count
);
  localparam int ALIAS_W = SET_W - LOW_W;

  aic_state_e           state_q;
  logic [TAG_W-1:0]     ptag_q;
  logic [LOW_W-1:0]     low_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [ALIAS_W-1:0]   alias_q;
  logic                 alias_last;
  logic                 accept;
  logic                 step;
  logic [WAYS-1:0]      hit;
  logic [CNT_W-1:0]     hit_cnt;

  assign accept = (state_q == ST_IDLE) && miss_valid;
  assign step   = (state_q == ST_INVAL) && !alias_last;

  aic_alias_seq #(.ALIAS_W(ALIAS_W)) i_seq (
    .clk     (clk),
    .rst     (rst),
    .clear   (accept),
    .step    (step),
    .alias_q (alias_q),
    .last    (alias_last)
  );

  aic_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .CNT_W(CNT_W)) i_match (
    .way_valid (rd_valid),
    .way_tags  (rd_tags),
    .ref_tag   (ptag_q),
    .hit       (hit),
    .hit_cnt   (hit_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ptag_q  <= '0;
      low_q   <= '0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (miss_valid) begin
          ptag_q  <= miss_ptag;
          low_q   <= miss_pidx;
          cnt_q   <= '0;
          state_q <= ST_PROBE;
        end
        ST_PROBE: state_q <= ST_INVAL;
        ST_INVAL: begin
          cnt_q   <= cnt_q + hit_cnt;
          state_q <= alias_last ? ST_DONE : ST_PROBE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle      = (state_q == ST_IDLE);
  assign done      = (state_q == ST_DONE);
  assign rd_en     = (state_q == ST_PROBE);
  assign rd_set    = {alias_q, low_q};
  assign inv_en    = (state_q == ST_INVAL) && (|hit);
  assign inv_set   = {alias_q, low_q};
  assign inv_way   = (state_q == ST_INVAL) ? hit : '0;
  assign inv_count = cnt_q;

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    idle |-> (!rd_en && !inv_en));

  // R4
  inv_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    inv_en |-> ($past(rd_en) && inv_set == $past(rd_set)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && idle));

  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (inv_count <= CNT_W'(NCAND)));

  // R8
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (idle && !$past(done) && !$past(accept)) |-> $stable(inv_count));
endmodule

// File: tb/test_alias_inval_checker.sv
module test_alias_inval_checker;
  localparam int TAG_W = 20;
  localparam int LOW_W = 6;
  localparam int SET_W = 8;
  localparam int NSET  = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic miss_valid = 1'b0;
  logic [LOW_W-1:0] miss_pidx = '0;
  logic [TAG_W-1:0] miss_ptag = '0;
  logic idle, rd_en, inv_en, done;
  logic [SET_W-1:0] rd_set, inv_set;
  logic [1:0] inv_way;
  logic [3:0] inv_count;
  logic [1:0] rd_valid = '0;
  logic [2*TAG_W-1:0] rd_tags = '0;

  logic [TAG_W-1:0] mtag [NSET][2];
  logic             mval [NSET][2];
  logic [SET_W-1:0] rdlog [8];
  int nrd = 0;
  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  alias_inval_checker i_alias_inval_checker (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_pidx(miss_pidx),
    .miss_ptag(miss_ptag), .idle(idle), .rd_en(rd_en), .rd_set(rd_set),
    .rd_valid(rd_valid), .rd_tags(rd_tags), .inv_en(inv_en), .inv_set(inv_set),
    .inv_way(inv_way), .done(done), .inv_count(inv_count)
  );

  // tag array model: one-cycle read, invalidate at the edge
  always @(posedge clk) begin
    if (rd_en) begin
      rd_valid <= {mval[rd_set][1], mval[rd_set][0]};
      rd_tags  <= {mtag[rd_set][1], mtag[rd_set][0]};
      if (nrd < 8) rdlog[nrd] <= rd_set;
      nrd <= nrd + 1;
    end
    if (inv_en) begin
      if (inv_way[0]) mval[inv_set][0] <= 1'b0;
      if (inv_way[1]) mval[inv_set][1] <= 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      tests++; fails++;
      $display("FAIL watchdog: act=%0d cycles exp<=50000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic load_bg();
    for (int s = 0; s < NSET; s++)
      for (int w = 0; w < 2; w++) begin
        mtag[s][w] = {8'hE0, s[7:0], 3'b000, w[0]};
        mval[s][w] = 1'b1;
      end
  endtask

  // stimulus/expect table: {pidx(8), ptag(20), placement mask(8), expected count(4)}
  localparam logic [39:0] VEC [6] = '{
    {8'h05, 20'h12345, 8'h00, 4'd0},
    {8'h07, 20'h00ABC, 8'h01, 4'd1},
    {8'h3F, 20'hFFFFF, 8'h03, 4'd2},
    {8'h00, 20'h55555, 8'hA5, 4'd4},
    {8'h2A, 20'h0F0F0, 8'hFF, 4'd8},
    {8'h11, 20'h00001, 8'h80, 4'd1}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check(idle && !done && !rd_en && !inv_en, "R1 in reset",
          {idle, done, rd_en, inv_en}, 4'b1000);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check(idle && !done && !rd_en && !inv_en, "R1 after reset",
          {idle, done, rd_en, inv_en}, 4'b1000);
    check(inv_count == 0, "R1 count", inv_count, 0);

    for (int v = 0; v < 6; v++) begin
      logic [5:0]  lo;
      logic [19:0] tg;
      logic [7:0]  mk;
      logic [3:0]  ex;
      int          islot;
      int          n;
      int          resid;
      int          cleared;
      int          others;
      lo = VEC[v][37:32]; tg = VEC[v][31:12]; mk = VEC[v][11:4]; ex = VEC[v][3:0];
      load_bg();
      islot = -1;
      for (int k = 0; k < 8; k++) begin
        if (mk[k]) begin
          mtag[{k[2:1], lo}][k & 1] = tg;
        end else if (islot < 0) begin
          islot = k;
          mtag[{k[2:1], lo}][k & 1] = tg;
          mval[{k[2:1], lo}][k & 1] = 1'b0;
        end
      end
      mtag[{2'd1, lo ^ 6'h01}][0] = tg;
      nrd = 0;
      miss_pidx = lo; miss_ptag = tg; miss_valid = 1'b1;
      @(posedge clk);
      @(negedge clk) miss_valid = 1'b0;
      n = 0;
      while (!done && n < 30) begin @(negedge clk); n++; end
      check(n == 8, "R7 done latency", n, 8);
      check(inv_count == ex, "R8 count", inv_count, ex);
      check(nrd == 4 && rdlog[0] == {2'd0, lo} && rdlog[1] == {2'd1, lo} &&
            rdlog[2] == {2'd2, lo} && rdlog[3] == {2'd3, lo},
            "R3 probe order", rdlog[3], {2'd3, lo});
      resid = 0; cleared = 0; others = 0;
      for (int k = 0; k < 8; k++) begin
        if (mval[{k[2:1], lo}][k & 1] && mtag[{k[2:1], lo}][k & 1] == tg) resid++;
        if (mk[k] && !mval[{k[2:1], lo}][k & 1]) cleared++;
        if (!mk[k] && k != islot && mval[{k[2:1], lo}][k & 1]) others++;
      end
      check(resid == 0, "R9 no residual copy", resid, 0);
      check(cleared == $countones(mk), "R4 matches cleared", cleared, $countones(mk));
      check(others == 8 - $countones(mk) - (islot >= 0 ? 1 : 0), "R6 others kept",
            others, 8 - $countones(mk) - (islot >= 0 ? 1 : 0));
      check(mval[{2'd1, lo ^ 6'h01}][0] == 1'b1, "R6 outside set kept",
            mval[{2'd1, lo ^ 6'h01}][0], 1);
      if (v == 2)
        check(!mval[{2'd0, lo}][0] && !mval[{2'd0, lo}][1], "R5 both ways",
              {mval[{2'd0, lo}][1], mval[{2'd0, lo}][0]}, 0);
      @(negedge clk);
      check(!done && idle, "R2 idle after done", {done, idle}, 2'b01);
      check(inv_count == ex, "R8 count held", inv_count, ex);
    end

    // R2: miss raised during a walk is ignored
    begin
      int n;
      int extra;
      load_bg();
      mtag[8'h09][0] = 20'h0AAAA;
      mtag[8'h09][1] = 20'h0BBBB;
      nrd = 0;
      miss_pidx = 6'h09; miss_ptag = 20'h0AAAA; miss_valid = 1'b1;
      @(posedge clk);
      @(negedge clk) miss_valid = 1'b0;
      n = 0;
      while (!done && n < 30) begin
        @(negedge clk); n++;
        if (n == 3) begin miss_ptag = 20'h0BBBB; miss_valid = 1'b1; end
        if (n == 4) miss_valid = 1'b0;
      end
      check(inv_count == 1, "R2 busy count", inv_count, 1);
      extra = 0;
      for (int i = 0; i < 12; i++) begin @(negedge clk); if (done) extra++; end
      check(extra == 0, "R2 no extra done", extra, 0);
      check(nrd == 4, "R2 no extra reads", nrd, 4);
      check(mval[8'h09][1] == 1'b1, "R2 busy miss ignored", mval[8'h09][1], 1);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule